// File: doc/BRIEF.md
# Work RAM Enable Glitch Filter

This block cleans up an active-low chip-enable before it reaches a work RAM. A bus mapper can decode an address too early. When that happens it drives brief false enable pulses. A write to a high address range can look for a moment like a work-RAM access, and a pulse that reaches the RAM could corrupt its contents.

The filter samples the raw enable with a clock. It lets an assertion through only after the input has stayed low for a programmable number of sample cycles. Release is different: the output goes inactive in the same instant the raw enable goes high, so a real access window is never stretched. This is a clocked counterpart of a resistor-capacitor delay with a bypass diode. The delay parameter is set so that the delay covers the longest expected false pulse, about 30 ns, with margin. The default of 8 cycles at 100 MHz gives roughly 80 ns.

The raw input passes through a two-stage synchroniser before the low-time counter sees it. The release path does not go through the synchroniser: it uses the raw input directly.

Top module: `ce_glitch_filter`

## Requirements
- R1: While reset is asserted, `ce_filt_n` is high. After reset is released it stays high until the input has qualified a new low period, counted from the release of reset.
- R2: After `ce_raw_n` goes low and stays low, `ce_filt_n` goes low just after the (LOW_CYCLES+2)-th rising clock edge at which the input is low. The two extra edges are the synchroniser latency.
- R3: A low pulse on `ce_raw_n` that covers at most LOW_CYCLES+1 rising edges produces no low level on `ce_filt_n` at any time.
- R4: When `ce_raw_n` goes high, `ce_filt_n` goes high in the same instant, with no clock edge needed.
- R5: Once the input has been high for at least 3 rising edges, the low-time count is cleared. A following low period must again last the full delay of R2 before the output asserts.
- R6: Once `ce_filt_n` is low, it stays low for as long as `ce_raw_n` remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_raw_n | input | 1 | Raw active-low enable from the mapper |
| ce_filt_n | output | 1 | Filtered active-low enable to the work RAM |

## Verification
The hardest case to reach is a low pulse that ends at the exact boundary. At LOW_CYCLES+1 edges the pulse must vanish; at LOW_CYCLES+2 edges it must give a single low cycle. The counter has already reached its limit internally when the first of these pulses ends. The stimulus table therefore drives low periods of exactly those two lengths, each followed by the shortest gap that clears the count. Every cycle of each low period is checked against the expected output level. A separate test holds the input low across a reset pulse, to show that the delay starts again from the release of reset.

// File: rtl/cef_pkg.sv
package cef_pkg;
  localparam int unsigned CEF_DEF_LOW_CYCLES = 8;
  localparam int unsigned CEF_SYNC_STAGES    = 2;
endpackage

// File: rtl/cef_sync.sv
module cef_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/cef_low_timer.sv
module cef_low_timer #(
  parameter int unsigned LOW_CYCLES = 8,
  localparam int unsigned CW = $clog2(LOW_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_n,
  output logic          qual,
  output logic [CW-1:0] low_cnt
);
  localparam logic [CW-1:0] LIMIT  = CW'(LOW_CYCLES);
  localparam logic [CW-1:0] PRELIM = CW'(LOW_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      qual    <= 1'b0;
    end else if (sync_n) begin
      low_cnt <= '0;
      qual    <= 1'b0;
    end else begin
      if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
      qual <= (low_cnt >= PRELIM);
    end
  end

  AST_QUAL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> !$past(sync_n)); // R2
  AST_QUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !sync_n) |=> qual); // R6
endmodule

// File: rtl/ce_glitch_filter.sv
module ce_glitch_filter #(
  parameter int unsigned LOW_CYCLES = cef_pkg::CEF_DEF_LOW_CYCLES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_raw_n,
  output logic ce_filt_n
);
  localparam int unsigned CW = $clog2(LOW_CYCLES + 1);

  logic          sync_n;
  logic          qual;
  logic [CW-1:0] low_cnt;

  cef_sync #(.STAGES(cef_pkg::CEF_SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (ce_raw_n),
    .q_out (sync_n)
  );

  cef_low_timer #(.LOW_CYCLES(LOW_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_n  (sync_n),
    .qual    (qual),
    .low_cnt (low_cnt)
  );

  // Release bypasses the synchroniser: raw high forces the output inactive.
  assign ce_filt_n = ce_raw_n | ~qual;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ce_filt_n); // R1
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |=> (low_cnt == '0)); // R5
  AST_FALL_AFTER_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_filt_n) |-> (low_cnt == CW'(LOW_CYCLES))); // R3
endmodule

// File: tb/ce_glitch_filter_tb.sv
module ce_glitch_filter_tb;
  localparam int unsigned LOWC = 8;
  localparam int unsigned FALL_AT = LOWC + 2;
  localparam int NV = 9;
  // each entry: {low edges, high gap edges}
  localparam int VEC [NV][2] = '{
    '{20, 6}, '{9, 4}, '{10, 3}, '{11, 3}, '{1, 4},
    '{3, 5}, '{30, 3}, '{12, 8}, '{2, 3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_raw_n = 1'b1;
  logic ce_filt_n;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ce_glitch_filter #(.LOW_CYCLES(LOWC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_raw_n(ce_raw_n), .ce_filt_n(ce_filt_n)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ce_filt_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(ce_filt_n, 1'b1, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ce_filt_n, 1'b1, "R1 idle after reset");

    // Table walk: R2 timing, R3 short pulses, R6 hold, R4 release, R5 re-qualify
    for (int v = 0; v < NV; v++) begin
      int bad;
      bad = 0;
      ce_raw_n = 1'b0;
      for (int i = 1; i <= VEC[v][0]; i++) begin
        logic e;
        @(negedge clk);
        e = (i >= FALL_AT) ? 1'b0 : 1'b1;
        if (ce_filt_n !== e) begin
          bad++;
          $display("FAIL R2/R3/R5/R6 vec %0d cycle %0d: ce_filt_n=%b expected %b",
                   v, i, ce_filt_n, e);
        end
      end
      checks++;
      if (bad != 0) errors++;
      ce_raw_n = 1'b1;
      #1;
      chk(ce_filt_n, 1'b1, "R4 immediate release");
      repeat (VEC[v][1]) @(negedge clk);
    end

    // R3: pulse of exactly LOWC+1 edges gives nothing, watched for extra cycles
    ce_raw_n = 1'b0;
    repeat (LOWC + 1) @(negedge clk);
    ce_raw_n = 1'b1;
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (ce_filt_n !== 1'b1) lows++;
      end
      chk(lows == 0 ? 1'b1 : 1'b0, 1'b1, "R3 boundary pulse suppressed");
    end

    // R4: release mid-cycle, checked before any clock edge
    ce_raw_n = 1'b0;
    repeat (FALL_AT + 2) @(negedge clk);
    chk(ce_filt_n, 1'b0, "R6 held low");
    #2 ce_raw_n = 1'b1;
    #0.5;
    chk(ce_filt_n, 1'b1, "R4 release without clock edge");
    repeat (4) @(negedge clk);

    // R1: input held low across a reset pulse restarts the delay
    ce_raw_n = 1'b0;
    repeat (FALL_AT + 1) @(negedge clk);
    chk(ce_filt_n, 1'b0, "R2 low before reset");
    rst_n = 1'b0;
    #1;
    chk(ce_filt_n, 1'b1, "R1 reset forces inactive");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (FALL_AT - 1) @(negedge clk);
    chk(ce_filt_n, 1'b1, "R1 delay restarts after reset");
    @(negedge clk);
    chk(ce_filt_n, 1'b0, "R1 qualified after reset");
    ce_raw_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ce_filt_n, 1'b1, "R4 idle at end");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule